// File: doc/BRIEF.md
# Deep-Buffer Serial Port

A memory-mapped asynchronous serial port for a 32-bit processor bus. A transmitter and a receiver each run from their own 16x prescaler, and a programmable divisor sets the bit time. With a 100 MHz clock, a divisor of 1 gives 6 250 000 baud, 2 gives 3 125 000 baud, and larger values reach 300 baud. The standard rates up to 460 800 baud and the high non-standard rates all fall within the 16-bit divisor range. Both directions buffer through deep RAM-backed FIFOs. The default depth is 1024 bytes.

Software writes bytes into the transmit FIFO one at a time. It drains the receive FIFO up to three bytes per read, and each byte carries its own valid flag, so an interrupt handler needs a third of the bus reads it would otherwise need. Neither edge of the block has a streaming handshake. On the transmit side, back-pressure is visible only as a full flag in the status register, and a write made while that flag is set is dropped. On the receive side, back-pressure is handled by dropping the incoming byte and setting an overrun flag.

Two interrupt lines are provided. One reports that receive data is waiting, and the other reports that the transmit buffer has room. Each has its own enable bit.

Top module: `bulk_uart`

## Requirements
- R1: Frames are 8N1. The line idles high, the start bit is low, the data follows least significant bit first, and the stop bit is high. Every bit lasts 16 × divisor clocks, where the divisor is CTRL[15:0] and a value of 0 acts as 1.
- R2: A write to offset 0x0 pushes bus_wdata[7:0] into the transmit FIFO. Bytes leave on txd in the order they were written.
- R3: When the transmit FIFO is full, STATUS bit 1 reads 1, and a write to offset 0x0 is ignored, so that byte is never sent.
- R4: A read of offset 0x4 returns the oldest byte in bits [7:0], the next in [15:8] and the third in [23:16]. Valid flags for those bytes sit in bits [26:24], are filled from bit 24 upward, and are 0 for absent bytes, whose data bits read 0. Only the flagged bytes are removed. Read data appears with bus_rvalid one cycle after the read request.
- R5: A low level on rxd that is no longer low at the middle of the start bit is discarded as a glitch. It stores no byte and sets no flag.
- R6: A frame whose stop bit samples low is discarded and sets the sticky framing flag, STATUS bit 2. Writing 1 to that bit of offset 0x8 clears it.
- R7: A byte that completes while the receive FIFO is full is dropped and sets the sticky overrun flag, STATUS bit 3. Writing 1 to that bit clears it. The bytes already stored are kept.
- R8: irq_rx equals CTRL bit 16 AND (the receive FIFO is not empty). STATUS bit 0 shows that the receive FIFO is not empty.
- R9: irq_tx equals CTRL bit 17 AND (the transmit FIFO holds fewer than DEPTH/2 bytes).
- R10: After reset both FIFOs are empty, which reads as STATUS = 0x10 (bit 4 means the transmit FIFO is empty). txd is high, CTRL reads 54, which is 115 200 baud at 100 MHz, and both interrupts are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 TX, 0x4 RX, 0x8 STATUS, 0xC CTRL |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| rxd | input | 1 | Serial input (asynchronous) |
| txd | output | 1 | Serial output |
| irq_rx | output | 1 | Receive data waiting |
| irq_tx | output | 1 | Transmit buffer below half full |

## Verification
The bench sends every byte value through a loopback. This catches a swapped bit order, a shifted sample point, or a stop bit of the wrong level in either direction.

The bench also aims at four corner cases:
- **Packed reads with one or two bytes waiting.** A design that popped three bytes anyway would lose data on the next read. A design that mis-filled the flags would return stale bytes marked as valid.
- **A full transmit FIFO.** It exposes a design that overwrote the oldest byte or sent a tenth frame.
- **A full receive FIFO.** It exposes a design that corrupted stored bytes instead of dropping the newcomer.
- **A short low pulse and a low stop bit.** They show whether noise is stored as data and whether a malformed frame leaks into the FIFO.

// File: rtl/bulk_uart_pkg.sv
package bulk_uart_pkg;
  localparam int PEEK = 3;

  localparam logic [1:0] OFS_TX   = 2'd0;
  localparam logic [1:0] OFS_RX   = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  localparam int ST_RX_AVAIL = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_FRAME    = 2;
  localparam int ST_OVR      = 3;
  localparam int ST_TX_EMPTY = 4;

  localparam int CT_RX_IE = 16;
  localparam int CT_TX_IE = 17;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/bu_prescale.sv
module bu_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = !clear && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (clear)                   cnt <= '0;
    else if (cnt == lim - DIV_W'(1))  cnt <= '0;
    else                              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/bu_fifo.sv
module bu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  parameter int PEEK  = 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(PEEK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic [PW-1:0]   pop_n,
  output logic [PEEK*W-1:0] dout,
  output logic [CW-1:0]   count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  assign push_ok = push && (count < CW'(DEPTH));

  for (genvar g = 0; g < PEEK; g++) begin : g_peek
    assign dout[g*W +: W] = mem[rd_ptr + AW'(g)];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_ok) - CW'(pop_n);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);
endmodule

// File: rtl/bu_tx.sv
module bu_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             txd
);
  logic       busy;
  logic [8:0] shreg;
  logic [3:0] bitn;
  logic [3:0] tcnt;
  logic       tick;

  assign fifo_pop = !busy && !fifo_empty;

  bu_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(fifo_pop), .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      shreg <= '1;
      bitn  <= '0;
      tcnt  <= '0;
    end else if (fifo_pop) begin
      busy  <= 1'b1;
      txd   <= 1'b0;
      shreg <= {1'b1, fifo_data};
      bitn  <= '0;
      tcnt  <= '0;
    end else if (busy && tick) begin
      tcnt <= tcnt + 4'd1;
      if (tcnt == 4'd15) begin
        if (bitn == 4'd9) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd   <= shreg[0];
          shreg <= {1'b1, shreg[8:1]};
          bitn  <= bitn + 4'd1;
        end
      end
    end
  end

  // R1: the line only moves at the end of a 16-tick bit period while sending
  a_r1_edge_on_bit_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (txd != $past(txd))) |-> $past(tick && tcnt == 4'd15));
endmodule

// File: rtl/bu_rx.sv
module bu_rx
  import bulk_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             frame_err
);
  logic      s1, s2;
  rx_state_e state;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic       tick;
  logic       clear;

  assign clear = (state == RX_IDLE) && !s2;

  bu_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clear), .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bitn       <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        RX_IDLE: if (!s2) begin
          state <= RX_START;
          tcnt  <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == 4'd7) begin
            tcnt  <= '0;
            bitn  <= '0;
            state <= s2 ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_DATA: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            byte_data <= {s2, byte_data[7:1]};
            bitn      <= bitn + 3'd1;
            if (bitn == 3'd7) state <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            if (s2) byte_valid <= 1'b1;
            else    frame_err  <= 1'b1;
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R5: data reception begins only after a low sample at mid start bit
  a_r5_mid_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(s2));
endmodule

// File: rtl/bulk_uart.sv
module bulk_uart
  import bulk_uart_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 54
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_rx,
  output logic        irq_tx
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       ofs;
  logic             wr, rd, rd_rx;
  logic [DIV_W-1:0] div_q;
  logic             rx_ie, tx_ie, ferr, ovr;
  logic [CW-1:0]    tx_count, rx_count;
  logic             tx_full, rx_full, tx_pop;
  logic [7:0]       tx_head;
  logic [PEEK*8-1:0] rx_peek;
  logic [1:0]       avail, rx_pop_n;
  logic             rx_byte_valid, rx_frame_err;
  logic [7:0]       rx_byte;
  logic [31:0]      rmux, rx_word;
  logic             wr_tx, clr_stat;
  logic             unused_ok;

  assign unused_ok = ^{bus_wdata[31:18], bus_addr[1:0]};

  assign ofs      = bus_addr[3:2];
  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign rd_rx    = rd && (ofs == OFS_RX);
  assign wr_tx    = wr && (ofs == OFS_TX);
  assign clr_stat = wr && (ofs == OFS_STAT);
  assign tx_full  = (tx_count == CW'(DEPTH));
  assign rx_full  = (rx_count == CW'(DEPTH));
  assign avail    = (rx_count >= CW'(3)) ? 2'd3 : rx_count[1:0];
  assign rx_pop_n = rd_rx ? avail : 2'd0;

  bu_fifo #(.W(8), .DEPTH(DEPTH), .PEEK(1)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_tx && !tx_full), .din(bus_wdata[7:0]),
    .pop_n(tx_pop), .dout(tx_head), .count(tx_count)
  );

  bu_fifo #(.W(8), .DEPTH(DEPTH), .PEEK(PEEK)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_byte_valid && !rx_full), .din(rx_byte),
    .pop_n(rx_pop_n), .dout(rx_peek), .count(rx_count)
  );

  bu_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .fifo_empty(tx_count == '0),
    .fifo_data(tx_head), .fifo_pop(tx_pop), .txd(txd)
  );

  bu_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .rxd(rxd),
    .byte_valid(rx_byte_valid), .byte_data(rx_byte), .frame_err(rx_frame_err)
  );

  always_comb begin
    rx_word = '0;
    for (int i = 0; i < PEEK; i++) begin
      if (2'(i) < avail) begin
        rx_word[i*8 +: 8] = rx_peek[i*8 +: 8];
        rx_word[24 + i]   = 1'b1;
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (ofs)
      OFS_RX: rmux = rx_word;
      OFS_STAT: begin
        rmux[ST_RX_AVAIL] = (rx_count != '0);
        rmux[ST_TX_FULL]  = tx_full;
        rmux[ST_FRAME]    = ferr;
        rmux[ST_OVR]      = ovr;
        rmux[ST_TX_EMPTY] = (tx_count == '0);
      end
      OFS_CTRL: begin
        rmux[DIV_W-1:0] = div_q;
        rmux[CT_RX_IE]  = rx_ie;
        rmux[CT_TX_IE]  = tx_ie;
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      div_q      <= DIV_W'(DIV_RESET);
      rx_ie      <= 1'b0;
      tx_ie      <= 1'b0;
      ferr       <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
      if (wr && ofs == OFS_CTRL) begin
        div_q <= bus_wdata[DIV_W-1:0];
        rx_ie <= bus_wdata[CT_RX_IE];
        tx_ie <= bus_wdata[CT_TX_IE];
      end
      if (rx_frame_err)                        ferr <= 1'b1;
      else if (clr_stat && bus_wdata[ST_FRAME]) ferr <= 1'b0;
      if (rx_byte_valid && rx_full)            ovr <= 1'b1;
      else if (clr_stat && bus_wdata[ST_OVR])  ovr <= 1'b0;
    end
  end

  assign irq_rx = rx_ie && (rx_count != '0);
  assign irq_tx = tx_ie && (tx_count < CW'(DEPTH / 2));

  a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full) |=> (tx_count <= $past(tx_count)));
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(clr_stat && bus_wdata[ST_OVR])) |=> ovr);
  a_r4_flags_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(rd_rx)) |->
      (bus_rdata[26:24] == 3'b000 || bus_rdata[26:24] == 3'b001 ||
       bus_rdata[26:24] == 3'b011 || bus_rdata[26:24] == 3'b111));
endmodule

// File: tb/bulk_uart_bench.sv
module bulk_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        txd, irq_rx, irq_tx;
  logic        drv_rxd = 1'b1;
  logic        loop_en = 1'b0;
  logic        rxd_line;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;
  assign rxd_line = loop_en ? txd : drv_rxd;

  bulk_uart #(.DEPTH(8)) u_bulk_uart (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rxd(rxd_line), .txd(txd),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    if (bus_rvalid !== 1'b1) check("R4 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic cap_frame(input int div, output logic [7:0] b, output logic stopb);
    int guard = 0;
    while (txd === 1'b1 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (8 * div) @(negedge clk);
    check("R1 start bit low", {31'd0, txd}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (16 * div) @(negedge clk);
      b[i] = txd;
    end
    repeat (16 * div) @(negedge clk);
    stopb = txd;
  endtask

  task automatic send_rx(input int div, input logic [7:0] b, input logic stopb);
    drv_rxd = 1'b0;
    repeat (16 * div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_rxd = b[i];
      repeat (16 * div) @(negedge clk);
    end
    drv_rxd = stopb;
    repeat (16 * div) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (16 * div) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        sb;
    logic [7:0]  got [9];
    logic        gstop [9];
    int          n;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 txd idle", {31'd0, txd}, 32'd1);
    check("R10 irq_rx", {31'd0, irq_rx}, 32'd0);
    check("R10 irq_tx", {31'd0, irq_tx}, 32'd0);
    bus_read(4'h8, d); check("R10 status", d, 32'h10);
    bus_read(4'hC, d); check("R10 ctrl", d, 32'd54);

    bus_write(4'hC, 32'h0003_0001);
    @(negedge clk);
    check("R9 irq_tx empty", {31'd0, irq_tx}, 32'd1);
    check("R8 irq_rx empty", {31'd0, irq_rx}, 32'd0);

    // R1 R2 R4: loopback sweep over every byte value
    loop_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      bus_write(4'h0, 32'(v));
      cap_frame(1, b, sb);
      check("R2 tx byte", {24'd0, b}, 32'(v));
      check("R1 stop high", {31'd0, sb}, 32'd1);
      repeat (16) @(negedge clk);
      bus_read(4'h4, d);
      check("R4 single byte read", d, 32'h0100_0000 | 32'(v));
    end
    loop_en = 1'b0;
    repeat (40) @(negedge clk);

    // R4 R8: packed reads of five bytes
    for (int i = 0; i < 5; i++) send_rx(1, 8'hA1 + 8'(i), 1'b1);
    check("R8 irq_rx data", {31'd0, irq_rx}, 32'd1);
    bus_read(4'h8, d); check("R8 status avail", d & 32'h1, 32'h1);
    bus_read(4'h4, d); check("R4 three bytes", d, 32'h07A3_A2A1);
    bus_read(4'h4, d); check("R4 two bytes", d, 32'h0300_A5A4);
    bus_read(4'h4, d); check("R4 no bytes", d, 32'h0);
    check("R8 irq_rx drained", {31'd0, irq_rx}, 32'd0);

    bus_write(4'hC, 32'h0002_0001);
    send_rx(1, 8'h5E, 1'b1);
    check("R8 irq_rx disabled", {31'd0, irq_rx}, 32'd0);
    bus_read(4'h4, d); check("R8 byte held", d, 32'h0100_005E);
    bus_write(4'hC, 32'h0003_0001);

    // R5: short low pulse
    drv_rxd = 1'b0;
    repeat (3) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (200) @(negedge clk);
    bus_read(4'h4, d); check("R5 glitch no data", d, 32'h0);
    bus_read(4'h8, d); check("R5 glitch no flags", d, 32'h10);

    // R6: low stop bit
    send_rx(1, 8'h55, 1'b0);
    repeat (40) @(negedge clk);
    bus_read(4'h8, d); check("R6 frame flag", d, 32'h14);
    bus_read(4'h4, d); check("R6 frame discarded", d, 32'h0);
    bus_write(4'h8, 32'h4);
    bus_read(4'h8, d); check("R6 frame cleared", d, 32'h10);

    // R7: overrun with nine bytes into depth eight
    for (int i = 0; i < 9; i++) send_rx(1, 8'h10 + 8'(i), 1'b1);
    bus_read(4'h8, d); check("R7 overrun flag", d, 32'h19);
    bus_read(4'h4, d); check("R7 keep 0-2", d, 32'h0712_1110);
    bus_read(4'h4, d); check("R7 keep 3-5", d, 32'h0715_1413);
    bus_read(4'h4, d); check("R7 keep 6-7", d, 32'h0300_1716);
    bus_read(4'h4, d); check("R7 ninth dropped", d, 32'h0);
    bus_read(4'h8, d); check("R7 still sticky", d, 32'h18);
    bus_write(4'h8, 32'h8);
    bus_read(4'h8, d); check("R7 cleared", d, 32'h10);

    // R3 R9: fill the transmit FIFO
    fork
      begin
        for (int i = 0; i < 10; i++) bus_write(4'h0, 32'h60 + 32'(i));
        bus_read(4'h8, d); check("R3 tx full flag", d & 32'h2, 32'h2);
        check("R9 irq_tx when full", {31'd0, irq_tx}, 32'd0);
      end
      begin
        for (int k = 0; k < 9; k++) cap_frame(1, got[k], gstop[k]);
      end
    join
    for (int k = 0; k < 9; k++) begin
      check("R3 tx order", {24'd0, got[k]}, 32'h60 + 32'(k));
      check("R1 tx stop", {31'd0, gstop[k]}, 32'd1);
    end
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) n++;
    end
    check("R3 dropped byte never sent", 32'(n), 32'd0);
    bus_read(4'h8, d); check("R3 tx drained", d, 32'h10);
    check("R9 irq_tx after drain", {31'd0, irq_tx}, 32'd1);

    // R1: divisor 3 gives 48-clock bits
    bus_write(4'hC, 32'h0003_0003);
    bus_write(4'h0, 32'hA5);
    n = 0;
    while (txd === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (txd === 1'b0 && n < 1000) begin n++; @(negedge clk); end
    check("R1 bit time div3", 32'(n), 32'd48);
    repeat (600) @(negedge clk);
    send_rx(3, 8'h3C, 1'b1);
    bus_read(4'h4, d); check("R1 rx at div3", d, 32'h0100_003C);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule